// File: doc/BRIEF.md
# Circular DMA Address Pointer with Boundary Interrupt

This block generates the byte address for one audio DMA stream that walks a contiguous ring buffer in memory. Software programs a start address, an end address (start plus buffer length) and a 4-bit interval code, then raises the stream's transfer enable. Each accepted bus word moves the pointer on by four bytes. When the pointer lands on the end address it is sent back to the start. Addresses are treated as physical; no page translation is applied.

Each time a word step lands the pointer on an address whose low `5 + code` bits are all zero, the block raises a one-cycle interrupt pulse. The pulse also sets a sticky flag that software clears by writing a one. The interval code is set from the period length: code 0 for periods up to 32 bytes, otherwise the smallest code whose span of 2^(5+code) bytes covers the period. The current pointer and its offset from the start are presented on outputs so that software can tell how far into the ring the stream has progressed.

Top module: `dmaring_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), cur_ptr, buf_offset, irq_pulse and irq_flag are all zero, and the start address, end address and interval code registers are zero.
- R2: A write (cfg_we high) loads the register picked by cfg_sel at the next edge: 0 loads the start address, 1 loads the end address, 2 loads the interval code from cfg_wdata bits 7:4 with every other bit of that word ignored.
- R3: At the edge where xfer_en is first seen high after being low, cur_ptr is loaded with the start address, and a word_ok at that edge is not counted.
- R4: While xfer_en is high, each edge with word_ok high adds 4 to cur_ptr and an edge with word_ok low leaves it unchanged; while xfer_en is low, cur_ptr holds whatever word_ok does.
- R5: When xfer_en is high and cur_ptr equals the end address, the next edge loads cur_ptr with the start address; a word_ok at that edge is dropped.
- R6: irq_pulse is high for exactly the one cycle after a counted word step whose new pointer has its low 5+code bits all zero (code 0 gives a 32-byte interval, code 15 a 1 MB interval).
- R7: Reloading cur_ptr with the start address, on enable or on wrap, never raises irq_pulse.
- R8: buf_offset equals cur_ptr minus the start address, except that it reads zero when cur_ptr equals the end address.
- R9: irq_flag is set in the cycle after irq_pulse; a write with cfg_sel 3 and cfg_wdata bit 0 high clears it at the next edge, a write with bit 0 low has no effect, and a pulse arriving at the same edge as a clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 start, 1 end, 2 interval code, 3 flag clear |
| cfg_wdata | input | 32 | Write data |
| xfer_en | input | 1 | Stream transfer enable |
| word_ok | input | 1 | One bus word transferred this cycle |
| cur_ptr | output | 32 | Current byte address |
| buf_offset | output | 32 | Byte offset of cur_ptr within the ring |
| irq_pulse | output | 1 | One-cycle interval interrupt |
| irq_flag | output | 1 | Sticky interrupt status |

## Verification
The assertions take for granted that the end address is above the start address by a whole number of 4-byte words, so that stepping from the start reaches it exactly, and that the interval code gives boundaries at least 32 bytes apart, which keeps pulses from landing on neighbouring cycles. The stimulus only programs word-aligned start and end addresses with the end above the start, and changes the start or end address only while the stream is disabled, so the pointer never runs past the end. Random phases vary word_ok density, enable toggles, interval codes and flag-clear writes, including clears that coincide with a pulse.

// File: rtl/dmaring_pkg.sv
// Shared constants and register-select encoding for the circular DMA pointer.
// Assumes byte addressing and a fixed 4-byte bus word.
package dmaring_pkg;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_END   = 2'd1,
        SEL_CODE  = 2'd2,
        SEL_CLEAR = 2'd3
    } cfg_sel_e;

    localparam int CODE_W     = 4;   // width of the interval code
    localparam int CODE_LSB   = 4;   // code position inside the configuration word
    localparam int MIN_SHIFT  = 5;   // code 0 selects 2^5 = 32 bytes
    localparam int WORD_BYTES = 4;   // pointer step per transferred word

endpackage

// File: rtl/dmaring_cfg.sv
// Configuration registers: start address, end address and interval code.
// Also decodes the write-one-to-clear strobe for the interrupt flag.
// Assumes the writer keeps start and end word-aligned with end above start.
module dmaring_cfg
    import dmaring_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [AW-1:0]     start_q,
    output logic [AW-1:0]     end_q,
    output logic [CODE_W-1:0] code_q,
    output logic              clr_req
);

    cfg_sel_e sel;

    // Interpret the raw select bits as the register enum
    always_comb begin
        sel = cfg_sel_e'(cfg_sel);
    end

    // Load the addressed register on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            code_q  <= '0;
        end else if (cfg_we) begin
            case (sel)
                SEL_START: start_q <= cfg_wdata[AW-1:0];
                SEL_END:   end_q   <= cfg_wdata[AW-1:0];
                SEL_CODE:  code_q  <= cfg_wdata[CODE_LSB +: CODE_W];
                default:   ;
            endcase
        end
    end

    // Flag clear request: a write of one to bit 0 of the clear register
    always_comb begin
        clr_req = cfg_we && (sel == SEL_CLEAR) && cfg_wdata[0];
    end

endmodule

// File: rtl/dmaring_ptr.sv
// Pointer engine: reloads on enable rise and on reaching the end address,
// otherwise steps by one word per accepted transfer while enabled.
// Reports each counted step and the address it lands on.
module dmaring_ptr
    import dmaring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_en,
    input  logic          word_ok,
    input  logic [AW-1:0] start_q,
    input  logic [AW-1:0] end_q,
    output logic [AW-1:0] ptr_q,
    output logic          step_fire,
    output logic [AW-1:0] step_addr
);

    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic en_q;
    logic en_rise;
    logic at_end;

    // Previous enable, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= xfer_en;
        end
    end

    // Decode reload and step conditions for this cycle
    always_comb begin
        en_rise   = xfer_en && !en_q;
        at_end    = (ptr_q == end_q);
        step_addr = ptr_q + STEP;
        step_fire = xfer_en && !en_rise && !at_end && word_ok;
    end

    // Pointer register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (en_rise) begin
            ptr_q <= start_q;
        end else if (xfer_en && at_end) begin
            ptr_q <= start_q;
        end else if (step_fire) begin
            ptr_q <= step_addr;
        end
    end

endmodule

// File: rtl/dmaring_irq.sv
// Interval interrupt: builds the alignment mask from the code, pulses for one
// cycle when a counted step lands on an aligned address, and keeps a sticky
// flag cleared by software. A pulse beats a same-edge clear.
module dmaring_irq
    import dmaring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_q,
    input  logic              step_fire,
    input  logic [AW-1:0]     step_addr,
    input  logic              clr_req,
    output logic              irq_pulse,
    output logic              irq_flag
);

    logic [AW-1:0] mask;
    logic          aligned;

    // One mask bit per address bit: set below the interval shift
    for (genvar i = 0; i < AW; i++) begin : g_mask
        assign mask[i] = (i < (MIN_SHIFT + int'(code_q)));
    end

    // Boundary test on the landing address
    always_comb begin
        aligned = ((step_addr & mask) == '0);
    end

    // Single-cycle interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= step_fire && aligned;
        end
    end

    // Sticky flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (irq_pulse) begin
            irq_flag <= 1'b1;
        end else if (clr_req) begin
            irq_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/dmaring_offset.sv
// Position within the ring: pointer minus start, folded to zero when the
// pointer sits on the end address. Purely combinational.
module dmaring_offset #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr_q,
    input  logic [AW-1:0] start_q,
    input  logic [AW-1:0] end_q,
    output logic [AW-1:0] offset
);

    logic [AW-1:0] raw;
    logic [AW-1:0] span;

    // Distance from start and ring length, fold length to zero
    always_comb begin
        raw    = ptr_q - start_q;
        span   = end_q - start_q;
        offset = (raw == span) ? '0 : raw;
    end

endmodule

// File: rtl/dmaring_top.sv
// Circular DMA address pointer with power-of-two boundary interrupt.
// Assumes word-aligned start/end with end above start; physical addressing.
module dmaring_top
    import dmaring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          xfer_en,
    input  logic          word_ok,
    output logic [AW-1:0] cur_ptr,
    output logic [AW-1:0] buf_offset,
    output logic          irq_pulse,
    output logic          irq_flag
);

    logic [AW-1:0]     start_q;
    logic [AW-1:0]     end_q;
    logic [CODE_W-1:0] code_q;
    logic              clr_req;
    logic              step_fire;
    logic [AW-1:0]     step_addr;

    dmaring_cfg #(.AW(AW), .DW(32)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .start_q   (start_q),
        .end_q     (end_q),
        .code_q    (code_q),
        .clr_req   (clr_req)
    );

    dmaring_ptr #(.AW(AW)) i_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_en   (xfer_en),
        .word_ok   (word_ok),
        .start_q   (start_q),
        .end_q     (end_q),
        .ptr_q     (cur_ptr),
        .step_fire (step_fire),
        .step_addr (step_addr)
    );

    dmaring_irq #(.AW(AW)) i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_q    (code_q),
        .step_fire (step_fire),
        .step_addr (step_addr),
        .clr_req   (clr_req),
        .irq_pulse (irq_pulse),
        .irq_flag  (irq_flag)
    );

    dmaring_offset #(.AW(AW)) i_off (
        .ptr_q   (cur_ptr),
        .start_q (start_q),
        .end_q   (end_q),
        .offset  (buf_offset)
    );

endmodule

// File: rtl/dmaring_chk.sv
// Checker for dmaring_top, bound to every instance. Relies on end above start
// by whole words and on the start/end registers changing only while disabled.
module dmaring_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_en,
    input logic [AW-1:0] cur_ptr,
    input logic [AW-1:0] buf_offset,
    input logic          irq_pulse,
    input logic          irq_flag,
    input logic [AW-1:0] start_q,
    input logic [AW-1:0] end_q,
    input logic [3:0]    code_q
);

    logic [AW-1:0] span_mask;

    // Alignment mask computed independently of the design
    always_comb begin
        for (int b = 0; b < AW; b++) begin
            span_mask[b] = (b < 5 + int'(code_q));
        end
    end

    // R4
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> $stable(cur_ptr));

    // R3
    reload_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_en) |=> (cur_ptr == $past(start_q)));

    // R5
    wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && cur_ptr == end_q) |=> (cur_ptr == $past(start_q)));

    // R6
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R6
    pulse_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ((cur_ptr & span_mask) == '0));

    // R8
    offset_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ptr == end_q) |-> (buf_offset == '0));

    // R9
    flag_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> irq_flag);

endmodule

bind dmaring_top dmaring_chk #(.AW(AW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_en    (xfer_en),
    .cur_ptr    (cur_ptr),
    .buf_offset (buf_offset),
    .irq_pulse  (irq_pulse),
    .irq_flag   (irq_flag),
    .start_q    (start_q),
    .end_q      (end_q),
    .code_q     (code_q)
);

// File: tb/test_dmaring_top.sv
`timescale 1ns/1ps
module test_dmaring_top;

    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        xfer_en = 1'b0;
    logic        word_ok = 1'b0;
    logic [31:0] cur_ptr, buf_offset;
    logic        irq_pulse, irq_flag;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit live = 0;

    // reference model state
    logic [31:0] m_start = 0, m_end = 0, m_ptr = 0;
    int          m_code = 0;
    bit          m_enq = 0, m_pulse = 0, m_flag = 0;

    dmaring_top i_dmaring_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .xfer_en(xfer_en), .word_ok(word_ok),
        .cur_ptr(cur_ptr), .buf_offset(buf_offset),
        .irq_pulse(irq_pulse), .irq_flag(irq_flag)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // behavioural model, advanced on each edge from the applied inputs
    always @(posedge clk) begin
        logic [31:0] np;
        bit np_pulse, nf;
        if (!rst_n) begin
            m_start = 0; m_end = 0; m_ptr = 0; m_code = 0;
            m_enq = 0; m_pulse = 0; m_flag = 0;
        end else begin
            np = m_ptr; np_pulse = 0;
            if (xfer_en && !m_enq) np = m_start;
            else if (xfer_en && m_ptr == m_end) np = m_start;
            else if (xfer_en && word_ok) begin
                np = m_ptr + 4;
                np_pulse = ((np % (64'd1 << (5 + m_code))) == 0);
            end
            nf = m_pulse ? 1'b1 :
                 ((cfg_we && cfg_sel == 2'd3 && cfg_wdata[0]) ? 1'b0 : m_flag);
            if (cfg_we) begin
                if (cfg_sel == 2'd0) m_start = cfg_wdata;
                if (cfg_sel == 2'd1) m_end = cfg_wdata;
                if (cfg_sel == 2'd2) m_code = (cfg_wdata >> 4) & 15;
            end
            m_ptr = np; m_pulse = np_pulse; m_flag = nf; m_enq = xfer_en;
        end
    end

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        if (live) begin
            logic [31:0] eo;
            eo = (m_ptr == m_end) ? 32'd0 : m_ptr - m_start;
            check(cur_ptr == m_ptr, "R4 pointer", cur_ptr, m_ptr);
            check(buf_offset == eo, "R8 offset", buf_offset, eo);
            check(irq_pulse == m_pulse, "R6 pulse", irq_pulse, m_pulse);
            check(irq_flag == m_flag, "R9 flag", irq_flag, m_flag);
            if (irq_pulse) pulses++;
        end
    end

    // advance n edges, leaving time after the falling-edge compare
    task automatic cycle(input int n);
        repeat (n) begin
            @(posedge clk);
            #(CLK_T*3/4);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        cycle(1);
        cfg_we = 0;
    endtask

    initial begin
        #(CLK_T * 200000);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int p0;
        cycle(3);
        rst_n = 1;
        live = 1;
        // R1 reset state
        check(cur_ptr == 0 && buf_offset == 0, "R1 ptr/offset", cur_ptr, 0);
        check(!irq_pulse && !irq_flag, "R1 irq", {irq_pulse, irq_flag}, 0);

        // R2 configuration, code 1 with spare bits set (R2 ignored bits)
        wr(2'd0, 32'h0000_1000);
        wr(2'd1, 32'h0000_1100);
        wr(2'd2, 32'hFFFF_FF1F);
        xfer_en = 1; word_ok = 1;
        p0 = pulses;
        cycle(1);
        check(cur_ptr == 32'h1000, "R3 reload on enable", cur_ptr, 32'h1000);
        cycle(129);
        check(pulses - p0 == 8, "R6 64-byte interval count (R2 code)", pulses - p0, 8);
        check(cur_ptr == 32'h1100, "R5 reached end", cur_ptr, 32'h1100);
        check(buf_offset == 0, "R8 end folds to zero", buf_offset, 0);
        cycle(1);
        check(cur_ptr == 32'h1000, "R5 wrap drops word", cur_ptr, 32'h1000);
        check(!irq_pulse, "R7 no pulse on wrap", irq_pulse, 0);
        cycle(3);
        xfer_en = 0;
        cycle(5);
        check(cur_ptr == 32'h100C, "R4 hold while disabled", cur_ptr, 32'h100C);
        check(buf_offset == 32'hC, "R8 offset mid-ring", buf_offset, 32'hC);

        // flag clear behaviour
        wr(2'd3, 32'h0);
        check(irq_flag, "R9 zero write ignored", irq_flag, 1);
        wr(2'd3, 32'h1);
        check(!irq_flag, "R9 clear", irq_flag, 0);

        // code 0: 32-byte interval, set beats clear
        word_ok = 0;
        wr(2'd0, 32'h0000_2000);
        wr(2'd1, 32'h0000_2040);
        wr(2'd2, 32'h0000_0000);
        xfer_en = 1;
        cycle(1);
        check(cur_ptr == 32'h2000, "R3 reload new start", cur_ptr, 32'h2000);
        cycle(2);
        check(cur_ptr == 32'h2000, "R4 hold without word", cur_ptr, 32'h2000);
        word_ok = 1;
        cycle(8);
        check(irq_pulse && cur_ptr == 32'h2020, "R6 32-byte boundary", cur_ptr, 32'h2020);
        cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 32'h1;
        cycle(1);
        cfg_we = 0;
        check(irq_flag, "R9 set wins over clear", irq_flag, 1);
        cycle(7);
        check(irq_pulse && cur_ptr == 32'h2040, "R6 second boundary", cur_ptr, 32'h2040);

        // code 15: 1 MB interval crossed once
        xfer_en = 0;
        wr(2'd0, 32'h000F_FF80);
        wr(2'd1, 32'h0010_0080);
        wr(2'd2, 32'h0000_00F0);
        xfer_en = 1;
        p0 = pulses;
        cycle(65);
        check(pulses - p0 == 1, "R6 1MB interval count", pulses - p0, 1);
        check(cur_ptr == 32'h0010_0080, "R5 end at 1MB ring", cur_ptr, 32'h0010_0080);

        // random phase
        xfer_en = 0;
        wr(2'd0, 32'h0000_3000);
        wr(2'd1, 32'h0000_3100);
        for (int k = 0; k < 3000; k++) begin
            word_ok = ($urandom % 3) != 0;
            if ($urandom % 50 == 0) xfer_en = !xfer_en;
            if ($urandom % 40 == 0) begin
                cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = {31'd0, 1'($urandom)};
            end else if (!xfer_en && $urandom % 20 == 0) begin
                cfg_we = 1; cfg_sel = 2'd2; cfg_wdata = ($urandom % 4) << 4;
            end else begin
                cfg_we = 0;
            end
            cycle(1);
        end
        cfg_we = 0;

        // R1 reset mid-run
        rst_n = 0;
        cycle(1);
        rst_n = 1;
        check(cur_ptr == 0 && !irq_flag, "R1 reset again", cur_ptr, 0);
        cycle(2);
        finish_run();
    end

endmodule